// File: doc/BRIEF.md
# Byte-Lane Keyed Block Cipher

This block enciphers or deciphers a wide data block by treating it as a row of independent 8-bit characters. Every character uses the same 8-bit key. A character is scrambled in three steps. It is XORed with the key. It is then XORed with a mixing constant derived from the key. Finally its bit order is mirrored. Deciphering undoes these steps in the opposite order.

The mixing constant is the XOR of two modular powers, each taken modulo 256. The first power has the character width (8) as its base and the key as its exponent. The second power has the key as both base and exponent. A small sequential scheduler works the constant out after each key load, by repeated multiplication. The block reports busy while this runs.

A block request is accepted only while the block is not busy. The result is registered on the output one cycle after the request is accepted, and a one-cycle done pulse marks it. The result then stays put until the next accepted request. A key being computed does not affect the key in use until its constant is ready. This lets a block request and a key change share a cycle.

Top module: `byte_cipher`

## Requirements
- R1: A synchronous active-high reset clears `dout` and `done` to 0, drops `busy`, and makes key 0 the key in use. With key 0 the mixing constant is 0, so enciphering only mirrors the bits of each byte.
- R2: A cycle with `key_load` high captures `key_in`. For key k, `busy` is high for exactly k+1 cycles starting the cycle after the load.
- R3: The mixing constant for key k is (8^k mod 256) XOR (k^k mod 256), where any value raised to the power 0 gives 1. Example: key 3 gives 0x1B, and key 255 gives 0xFF.
- R4: With `mode_dec` = 0, each byte p at bits [8i+7:8i] becomes rev(p XOR k XOR m). Here m is the mixing constant, and rev swaps bit 7 with bit 0, bit 6 with bit 1, and so on. Example: key 3 turns byte 0x41 into 0x9A.
- R5: With `mode_dec` = 1, each byte c becomes rev(c) XOR m XOR k. Enciphering a block and then deciphering the result under the same key returns the original block.
- R6: A `start` sampled while `busy` is low is accepted. The cycle after, `dout` holds the result and `done` is high for that one cycle.
- R7: A `start` sampled while `busy` is high is ignored. `done` stays low and `dout` is unchanged.
- R8: `dout` keeps its value until the next accepted `start`, whatever `din`, `mode_dec` and the key inputs do.
- R9: If `key_load` and `start` fall in the same cycle while `busy` is low, the block is processed under the key that was in use before. The new key takes effect only once `busy` falls.
- R10: A `key_load` while `busy` is high abandons the computation in progress and restarts it for the new key. `busy` then lasts k+1 cycles for the new key k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_load | input | 1 | Load `key_in` and start computing its mixing constant |
| key_in | input | 8 | New key value |
| mode_dec | input | 1 | 0 = encipher, 1 = decipher |
| start | input | 1 | Request processing of `din` |
| din | input | 128 | Input block, 16 bytes |
| dout | output | 128 | Registered result block |
| done | output | 1 | One-cycle pulse when a new result is on `dout` |
| busy | output | 1 | Mixing constant is being computed; `start` is ignored |

## Verification
Two events can land on the same clock edge: a block request and a key load. The bench raises `start` and `key_load` together while the block is idle, with a new key that differs from the key in use. It then checks that the result matches a model computed under the old key. After `busy` falls, a second request must match the new key. Requests made during the key computation are also checked, to confirm that they leave `dout` and `done` untouched.

// File: rtl/bc_pkg.sv
package bc_pkg;

    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    typedef enum logic {
        MODE_ENC = 1'b0,
        MODE_DEC = 1'b1
    } mode_e;

    typedef enum logic {
        KS_IDLE = 1'b0,
        KS_RUN  = 1'b1
    } ks_state_e;

    // key in use together with its mixing constant
    typedef struct packed {
        char_t key;
        char_t mix;
    } keyset_t;

    function automatic char_t mirror(input char_t v);
        char_t r;
        for (int b = 0; b < CHAR_W; b++) begin
            r[b] = v[CHAR_W-1-b];
        end
        return r;
    endfunction

    function automatic char_t mul_mod(input char_t a, input char_t b);
        logic [2*CHAR_W-1:0] p;
        p = a * b;
        return p[CHAR_W-1:0];
    endfunction

endpackage

// File: rtl/bc_keysched.sv
module bc_keysched
    import bc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  char_t   key_in,
    output keyset_t active,
    output logic    busy
);

    localparam char_t BASE_N = char_t'(CHAR_W);

    ks_state_e state;
    char_t     pend_key;
    char_t     iter;
    char_t     pow_n;
    char_t     pow_k;
    keyset_t   active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= KS_IDLE;
            pend_key <= '0;
            iter     <= '0;
            pow_n    <= '0;
            pow_k    <= '0;
            active_q <= '0;
        end else if (load) begin
            pend_key <= key_in;
            iter     <= '0;
            pow_n    <= char_t'(1);
            pow_k    <= char_t'(1);
            state    <= KS_RUN;
        end else if (state == KS_RUN) begin
            if (iter == pend_key) begin
                active_q.key <= pend_key;
                active_q.mix <= pow_n ^ pow_k;
                state        <= KS_IDLE;
            end else begin
                pow_n <= mul_mod(pow_n, BASE_N);
                pow_k <= mul_mod(pow_k, pend_key);
                iter  <= iter + char_t'(1);
            end
        end
    end

    assign active = active_q;
    assign busy   = (state == KS_RUN);

endmodule

// File: rtl/bc_lane.sv
module bc_lane
    import bc_pkg::*;
(
    input  char_t   lane_in,
    input  keyset_t ks,
    input  mode_e   mode,
    output char_t   lane_out
);

    char_t fwd;
    char_t inv;

    always_comb begin
        fwd = mirror(lane_in ^ ks.key ^ ks.mix);
        inv = mirror(lane_in) ^ ks.mix ^ ks.key;
        lane_out = (mode == MODE_DEC) ? inv : fwd;
    end

endmodule

// File: rtl/byte_cipher.sv
module byte_cipher
    import bc_pkg::*;
#(
    parameter int N_CHARS = 16,
    localparam int DATA_W = N_CHARS * CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_load,
    input  logic [CHAR_W-1:0] key_in,
    input  logic              mode_dec,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              done,
    output logic              busy
);

    keyset_t           ks;
    logic              ks_busy;
    logic              accept;
    logic [DATA_W-1:0] lanes_out;
    logic [DATA_W-1:0] dout_q;
    logic              done_q;
    mode_e             mode;

    bc_keysched u_keysched (
        .clk    (clk),
        .rst    (rst),
        .load   (key_load),
        .key_in (key_in),
        .active (ks),
        .busy   (ks_busy)
    );

    assign mode   = mode_e'(mode_dec);
    assign accept = start && !ks_busy;

    for (genvar i = 0; i < N_CHARS; i++) begin : g_lane
        bc_lane u_lane (
            .lane_in  (din[i*CHAR_W +: CHAR_W]),
            .ks       (ks),
            .mode     (mode),
            .lane_out (lanes_out[i*CHAR_W +: CHAR_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= accept;
            if (accept) begin
                dout_q <= lanes_out;
            end
        end
    end

    assign dout = dout_q;
    assign done = done_q;
    assign busy = ks_busy;

endmodule

// File: rtl/byte_cipher_chk.sv
module byte_cipher_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              key_load,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] dout
);

    // R2: a key load makes the scheduler busy on the next cycle
    assert_load_busy_R2: assert property (@(posedge clk) disable iff (rst)
        key_load |=> busy);

    // R6: done only follows an accepted request
    assert_done_cause_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start && !busy));

    // R7: a request during busy yields no done
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> !done);

    // R8: output holds when no request was accepted
    assert_dout_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(start && !busy)) |-> $stable(dout));

endmodule

bind byte_cipher byte_cipher_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .key_load (key_load),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .dout     (dout)
);

// File: tb/tb_byte_cipher.sv
`timescale 1ns/1ps
module tb_byte_cipher;

    localparam int NV = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         key_load = 1'b0;
    logic [7:0]   key_in = '0;
    logic         mode_dec = 1'b0;
    logic         start = 1'b0;
    logic [127:0] din = '0;
    logic [127:0] dout;
    logic         done;
    logic         busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    byte_cipher dut (
        .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in),
        .mode_dec(mode_dec), .start(start), .din(din),
        .dout(dout), .done(done), .busy(busy)
    );

    localparam logic [7:0]   V_KEY  [NV] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd200, 8'd255};
    localparam logic         V_MODE [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [127:0] V_DIN  [NV] = '{
        128'h00112233445566778899AABBCCDDEEFF,
        128'hF413579ABCDE24680123456789ABCDEF,
        128'hFFFFFFFFFFFFFFFF0000000000000000,
        128'h41414141414141414141414141414141,
        128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0,
        128'h8000000100000080DEADBEEFCAFEF00D
    };

    function automatic logic [7:0] m_mix(input logic [7:0] k);
        logic [7:0] a = 8'd1;
        logic [7:0] b = 8'd1;
        for (int i = 0; i < int'(k); i++) begin
            a = 8'(a * 8'd8);
            b = 8'(b * k);
        end
        return a ^ b;
    endfunction

    function automatic logic [7:0] m_rev(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = v[i];
        return r;
    endfunction

    function automatic logic [127:0] m_blk(input logic [7:0] k, input logic m, input logic [127:0] d);
        logic [127:0] r;
        logic [7:0]   c = m_mix(k);
        for (int i = 0; i < 16; i++) begin
            if (m) r[i*8 +: 8] = m_rev(d[i*8 +: 8]) ^ c ^ k;
            else   r[i*8 +: 8] = m_rev(d[i*8 +: 8] ^ k ^ c);
        end
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_key(input logic [7:0] k, output int n);
        key_in = k; key_load = 1'b1;
        @(negedge clk);
        key_load = 1'b0;
        n = 0;
        while (busy && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_blk(input logic m, input logic [127:0] d, output logic [127:0] res, output logic dn);
        mode_dec = m; din = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        res = dout; dn = done;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] r, r2, held;
        logic         dn;
        int           n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(dout == '0 && !done && !busy, "R1 reset", {dout[125:0], done, busy}, 128'h0);
        // R1: key 0 in use after reset, constant 0 -> mirror only
        run_blk(1'b0, V_DIN[0], r, dn);
        chk(r == m_blk(8'd0, 1'b0, V_DIN[0]), "R1 key0 mirror", r, m_blk(8'd0, 1'b0, V_DIN[0]));

        // vector table: R2 busy length, R3/R4/R5 data, R6 done pulse
        for (int v = 0; v < NV; v++) begin
            load_key(V_KEY[v], n);
            chk(n == int'(V_KEY[v]) + 1, "R2 busy length", 128'(n), 128'(int'(V_KEY[v]) + 1));
            run_blk(V_MODE[v], V_DIN[v], r, dn);
            chk(dn, "R6 done pulse", 128'(dn), 128'h1);
            chk(r == m_blk(V_KEY[v], V_MODE[v], V_DIN[v]), V_MODE[v] ? "R5 decipher" : "R3 R4 encipher",
                r, m_blk(V_KEY[v], V_MODE[v], V_DIN[v]));
            @(negedge clk);
            chk(!done, "R6 done one cycle", 128'(done), 128'h0);
        end

        // R4: known byte value, key 3, 0x41 -> 0x9A; R3 constant 0x1B
        load_key(8'd3, n);
        run_blk(1'b0, {16{8'h41}}, r, dn);
        chk(r == {16{8'h9A}}, "R4 known byte", r, {16{8'h9A}});
        chk(m_mix(8'd3) == 8'h1B && m_mix(8'd255) == 8'hFF, "R3 constant model", 128'(m_mix(8'd3)), 128'h1B);

        // R5: round trip
        load_key(8'd77, n);
        run_blk(1'b0, V_DIN[1], r, dn);
        run_blk(1'b1, r, r2, dn);
        chk(r2 == V_DIN[1], "R5 round trip", r2, V_DIN[1]);

        // R8: output holds while inputs move
        held = dout;
        din = ~din; mode_dec = ~mode_dec; key_in = 8'h5A;
        repeat (4) @(negedge clk);
        chk(dout == held && !done, "R8 hold", dout, held);

        // R7: start during busy ignored
        key_in = 8'd200; key_load = 1'b1;
        @(negedge clk);
        key_load = 1'b0;
        run_blk(1'b0, V_DIN[4], r, dn);
        chk(r == held && !dn, "R7 start ignored", r, held);
        n = 0;
        while (busy && n < 400) begin n++; @(negedge clk); end

        // R9: key load and start in the same cycle use the old key (200)
        key_in = 8'd9; key_load = 1'b1;
        run_blk(1'b0, V_DIN[3], r, dn);
        key_load = 1'b0;
        chk(dn && r == m_blk(8'd200, 1'b0, V_DIN[3]), "R9 old key", r, m_blk(8'd200, 1'b0, V_DIN[3]));
        n = 0;
        while (busy && n < 400) begin n++; @(negedge clk); end
        run_blk(1'b0, V_DIN[3], r, dn);
        chk(r == m_blk(8'd9, 1'b0, V_DIN[3]), "R9 new key", r, m_blk(8'd9, 1'b0, V_DIN[3]));

        // R10: reload while busy restarts
        key_in = 8'd50; key_load = 1'b1;
        @(negedge clk);
        key_load = 1'b0;
        repeat (3) @(negedge clk);
        load_key(8'd7, n);
        chk(n == 8, "R10 restart length", 128'(n), 128'd8);
        run_blk(1'b0, V_DIN[5], r, dn);
        chk(r == m_blk(8'd7, 1'b0, V_DIN[5]), "R10 restart key", r, m_blk(8'd7, 1'b0, V_DIN[5]));

        // R1: reset during busy returns to key 0
        key_in = 8'd100; key_load = 1'b1;
        @(negedge clk);
        key_load = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && dout == '0, "R1 reset mid busy", dout, 128'h0);
        run_blk(1'b0, V_DIN[2], r, dn);
        chk(r == m_blk(8'd0, 1'b0, V_DIN[2]), "R1 key0 after reset", r, m_blk(8'd0, 1'b0, V_DIN[2]));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule